// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers a vector of interrupt request lines into a pending register. It qualifies each pending bit with a mask bit and a global service enable, and offers the core the single highest-priority request that qualifies. Priority follows bit position: source 0 is the most urgent and the highest index is the least urgent. Three sources do not use the mask register. Source 0 is reset and source 1 is emulation, and neither of them is ever gated. Source 2 is power-down, and the global service enable still gates it.

Software reaches three registers through a one-cycle write port. The control register holds the nesting enable and the global service enable. The mask register holds one enable bit per source. The pending register accepts a direct write, so software can force requests on or clear them. Two command pulses turn global servicing on or off directly.

When the core takes an offered request with an acknowledge pulse, the block clears that pending bit and pushes the source index onto an active-level stack. A return pulse pops the stack and brings back the previous priority threshold. With nesting enabled, only a strictly more urgent source preempts the active one. With nesting disabled, nothing is offered while any service is active.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending, mask and control read-back values are all zero, `irq_valid` is 0 and `active_valid` is 0.
- R2: A write with `reg_sel`=0 updates the control register. Only bit 4 (nesting enable) and bit 5 (global service enable) store a value, and every other bit of `ctrl_rdata` reads 0.
- R3: A pending bit is set one cycle after its `irq_req` line is high. A write with `reg_sel`=2 loads the pending register from `reg_wdata`. When a hardware request and a software clear hit the same bit in the same cycle, the bit ends up set.
- R4: A source with index 3 or above is offered only when its pending bit is 1, its mask bit (written with `reg_sel`=1, 1 = enabled) is 1, and the global service enable is 1.
- R5: Sources 0 and 1 are offered whenever they are pending, whatever the mask register and the global service enable hold.
- R6: Source 2 ignores its mask bit, but it is not offered while the global service enable is 0.
- R7: Among the qualifying sources, `irq_id` names the one with the lowest index.
- R8: A pulse on `gie_set` sets the global service enable and a pulse on `gie_clr` clears it. Both commands override a control register write in the same cycle, and `gie_clr` wins if both pulse together.
- R9: An `irq_ack` while `irq_valid` is 1 clears the pending bit of `irq_id`. From the next cycle `active_valid` is 1 and `active_lvl` equals that index.
- R10: While a service is active, a request is offered only if nesting is enabled and its index is strictly below `active_lvl`. With nesting disabled, no request is offered while a service is active.
- R11: An `irq_rti` pulse pops the active stack. `active_lvl` returns to the previously active index, or `active_valid` drops to 0 when the stack becomes empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Request lines, index 0 most urgent |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control, 1 mask, 2 pending |
| reg_wdata | input | REG_W | Register write data |
| gie_set | input | 1 | Global service enable command |
| gie_clr | input | 1 | Global service disable command |
| irq_ack | input | 1 | Core takes the offered request |
| irq_rti | input | 1 | Core returns from the current service |
| irq_valid | output | 1 | A request is offered |
| irq_id | output | IW | Index of the offered request |
| active_valid | output | 1 | A service is in progress |
| active_lvl | output | IW | Index of the innermost active service |
| ctrl_rdata | output | REG_W | Control register read-back |
| mask_rdata | output | N_SRC | Mask register read-back |
| pend_rdata | output | N_SRC | Pending register read-back |

## Verification
The bench goes after the unusual gating of the power-down source. It must stay unaffected by a mask bit of 0 and still be suppressed by a global disable. A design that treated it like reset would offer it while servicing is off, and one that treated it like an ordinary source would never offer it with its mask bit clear.

The bench also clears a pending bit with software in the same cycle its line rises. A design that let software win would silently drop that request.

The bench drives nested preemption by source 0 and then unwinds it with two return pulses. A stack that lost the outer level would report no active service after the first return instead of level 2. Finally, the bench turns nesting off during an active service and checks that an urgent request is held back until the return.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2
    } reg_sel_e;

    localparam int CTRL_NEST_BIT = 4;
    localparam int CTRL_GIE_BIT  = 5;

    localparam int SRC_RESET = 0;
    localparam int SRC_EMU   = 1;
    localparam int SRC_PWD   = 2;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest set index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
    parameter int DEPTH = 16,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [LW-1:0] push_lvl,
    output logic          nonempty,
    output logic [LW-1:0] top_lvl
);
    localparam int SPW  = $clog2(DEPTH + 1);
    localparam int LIDX = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][LW-1:0] stk;
        logic [SPW-1:0]           sp;
    } stk_t;

    stk_t s_d, s_q;
    logic do_pop, do_push;
    logic [LIDX-1:0] wr_idx, top_idx;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.sp != '0);
        do_push = push && ((s_q.sp < SPW'(DEPTH)) || do_pop);
        wr_idx  = LIDX'(s_q.sp);
        top_idx = LIDX'(s_q.sp - SPW'(1));
        if (do_pop && do_push) begin
            s_d.stk[top_idx] = push_lvl;
        end else if (do_pop) begin
            s_d.sp = s_q.sp - SPW'(1);
        end else if (do_push) begin
            s_d.stk[wr_idx] = push_lvl;
            s_d.sp          = s_q.sp + SPW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign nonempty = (s_q.sp != '0);
    assign top_lvl  = nonempty ? s_q.stk[top_idx] : '0;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter  int N_SRC = 16,
    localparam int IW    = $clog2(N_SRC),
    localparam int REG_W = (N_SRC > 16) ? N_SRC : 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             gie_set,
    input  logic             gie_clr,
    input  logic             irq_ack,
    input  logic             irq_rti,
    output logic             irq_valid,
    output logic [IW-1:0]    irq_id,
    output logic             active_valid,
    output logic [IW-1:0]    active_lvl,
    output logic [REG_W-1:0] ctrl_rdata,
    output logic [N_SRC-1:0] mask_rdata,
    output logic [N_SRC-1:0] pend_rdata
);
    typedef struct packed {
        logic             nest;
        logic             gie;
        logic [N_SRC-1:0] mask;
        logic [N_SRC-1:0] pend;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [N_SRC-1:0] elig;
    logic             cand_found;
    logic [IW-1:0]    cand_id;
    logic             stk_nonempty;
    logic [IW-1:0]    stk_top;
    logic             take;

    // per-source qualification: reset/emulation free, power-down gated by gie only
    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        if (g == SRC_RESET || g == SRC_EMU) begin : g_free
            assign elig[g] = r_q.pend[g];
        end else if (g == SRC_PWD) begin : g_pwd
            assign elig[g] = r_q.pend[g] & r_q.gie;
        end else begin : g_mask
            assign elig[g] = r_q.pend[g] & r_q.mask[g] & r_q.gie;
        end
    end

    irq_prio_enc #(.N(N_SRC), .IW(IW)) u_enc (
        .req   (elig),
        .found (cand_found),
        .idx   (cand_id)
    );

    irq_lvl_stack #(.DEPTH(N_SRC), .LW(IW)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .pop      (irq_rti),
        .push_lvl (cand_id),
        .nonempty (stk_nonempty),
        .top_lvl  (stk_top)
    );

    always_comb begin
        irq_valid = cand_found &&
                    (!stk_nonempty || (r_q.nest && (cand_id < stk_top)));
        take      = irq_ack && irq_valid;

        r_d = r_q;
        if (reg_we) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_CTRL: begin
                    r_d.nest = reg_wdata[CTRL_NEST_BIT];
                    r_d.gie  = reg_wdata[CTRL_GIE_BIT];
                end
                SEL_MASK: r_d.mask = reg_wdata[N_SRC-1:0];
                SEL_PEND: r_d.pend = reg_wdata[N_SRC-1:0];
                default:  ;
            endcase
        end
        if (gie_set) r_d.gie = 1'b1;
        if (gie_clr) r_d.gie = 1'b0;
        if (take)    r_d.pend[cand_id] = 1'b0;
        r_d.pend = r_d.pend | irq_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ctrl_rdata                = '0;
        ctrl_rdata[CTRL_NEST_BIT] = r_q.nest;
        ctrl_rdata[CTRL_GIE_BIT]  = r_q.gie;
    end

    assign irq_id       = cand_id;
    assign active_valid = stk_nonempty;
    assign active_lvl   = stk_top;
    assign mask_rdata   = r_q.mask;
    assign pend_rdata   = r_q.pend;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter  int N_SRC = 16,
    localparam int IW    = $clog2(N_SRC),
    localparam int REG_W = (N_SRC > 16) ? N_SRC : 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_req,
    input logic             reg_we,
    input logic [1:0]       reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic             gie_set,
    input logic             gie_clr,
    input logic             irq_ack,
    input logic             irq_rti,
    input logic             irq_valid,
    input logic [IW-1:0]    irq_id,
    input logic             active_valid,
    input logic [IW-1:0]    active_lvl,
    input logic [REG_W-1:0] ctrl_rdata,
    input logic [N_SRC-1:0] mask_rdata,
    input logic [N_SRC-1:0] pend_rdata
);
    logic [REG_W-1:0] live_bits;
    always_comb begin
        live_bits                = '0;
        live_bits[CTRL_NEST_BIT] = 1'b1;
        live_bits[CTRL_GIE_BIT]  = 1'b1;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata & ~live_bits) == '0); // R2

    AST_HW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(irq_req) & ~pend_rdata) == '0)); // R3

    AST_MASKED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (int'(irq_id) > SRC_PWD)) |->
            (mask_rdata[irq_id] && ctrl_rdata[CTRL_GIE_BIT])); // R4

    AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> pend_rdata[irq_id]); // R7

    AST_PWD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (int'(irq_id) == SRC_PWD)) |-> ctrl_rdata[CTRL_GIE_BIT]); // R6

    AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid) |=>
            (active_valid && (active_lvl == $past(irq_id)))); // R9

    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_valid && !ctrl_rdata[CTRL_NEST_BIT]) |-> !irq_valid); // R10

    AST_NEST_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        (active_valid && irq_valid) |-> (irq_id < active_lvl)); // R10
endmodule

bind irq_prio_ctrl irq_prio_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
    localparam int N  = 16;
    localparam int IW = $clog2(N);
    localparam int K_IRQ = 0, K_PEND = 1, K_MASK = 2, K_CTRL = 3, K_ACT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [15:0]   reg_wdata = '0;
    logic          gie_set = 1'b0, gie_clr = 1'b0, irq_ack = 1'b0, irq_rti = 1'b0;
    logic          irq_valid, active_valid;
    logic [IW-1:0] irq_id, active_lvl;
    logic [15:0]   ctrl_rdata;
    logic [N-1:0]  mask_rdata, pend_rdata;

    irq_prio_ctrl #(.N_SRC(N)) u_dut (.*);

    always #10 clk = ~clk;

    typedef struct {
        string tag;
        int    kind;
        int    exp;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    function automatic int pair(input bit v, input int id);
        return v ? (32'h100 | id) : 0;
    endfunction

    task automatic ex(input string tag, input int kind, input int val);
        exp_t e;
        e.tag = tag; e.kind = kind; e.exp = val;
        q.push_back(e);
    endtask

    task automatic cyc(input bit we, input logic [1:0] sel, input logic [15:0] wd,
                       input logic [N-1:0] req, input bit en, input bit dis,
                       input bit ack, input bit rti);
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd; irq_req = req;
        gie_set = en; gie_clr = dis; irq_ack = ack; irq_rti = rti;
    endtask

    // monitor: compare queued expectations mid-cycle after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                int   act;
                e = q.pop_front();
                case (e.kind)
                    K_IRQ:   act = pair(irq_valid, int'(irq_id));
                    K_PEND:  act = int'(pend_rdata);
                    K_MASK:  act = int'(mask_rdata);
                    K_CTRL:  act = int'(ctrl_rdata);
                    default: act = pair(active_valid, int'(active_lvl));
                endcase
                n_chk++;
                if (act != e.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", e.tag, e.kind, act, e.exp);
                end
            end
        end
    end

    initial begin
        repeat (200) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        ex("R1 pend", K_PEND, 0); ex("R1 mask", K_MASK, 0); ex("R1 ctrl", K_CTRL, 0);
        ex("R1 irq", K_IRQ, 0);   ex("R1 act", K_ACT, 0);
        cyc(1, 0, 16'hFFFF, 0, 0, 0, 0, 0); ex("R2 ctrl all ones", K_CTRL, 32'h30);
        cyc(1, 0, 16'h0000, 0, 0, 0, 0, 0); ex("R2 ctrl clear", K_CTRL, 0);
        cyc(0, 0, 0, 16'h0020, 0, 0, 0, 0);
        ex("R3 hw set", K_PEND, 32'h20); ex("R4 masked off", K_IRQ, 0);
        cyc(1, 1, 16'h0020, 0, 0, 0, 0, 0);
        ex("R4 mask write", K_MASK, 32'h20); ex("R4 gie off", K_IRQ, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        ex("R8 gie_set", K_CTRL, 32'h20); ex("R4 offered", K_IRQ, pair(1, 5));
        cyc(1, 2, 16'h0000, 0, 0, 0, 0, 0);
        ex("R3 sw clear", K_PEND, 0); ex("R3 none", K_IRQ, 0);
        cyc(1, 2, 16'h0000, 16'h0020, 0, 0, 0, 0);
        ex("R3 hw over sw clear", K_PEND, 32'h20); ex("R3 offered", K_IRQ, pair(1, 5));
        cyc(1, 1, 16'h0000, 0, 0, 0, 0, 0); ex("R4 mask zero", K_IRQ, 0);
        cyc(1, 1, 16'h0020, 0, 0, 0, 0, 0); ex("R4 mask one", K_IRQ, pair(1, 5));
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        ex("R8 gie_clr", K_CTRL, 0); ex("R8 none", K_IRQ, 0);
        cyc(1, 2, 16'h0024, 0, 0, 0, 0, 0); ex("R6 pwd blocked", K_IRQ, 0);
        cyc(1, 0, 16'h0000, 0, 1, 0, 0, 0);
        ex("R8 cmd over write", K_CTRL, 32'h20); ex("R6 R7 pwd unmasked", K_IRQ, pair(1, 2));
        cyc(0, 0, 0, 0, 0, 1, 0, 0); ex("R6 off again", K_IRQ, 0);
        cyc(1, 2, 16'h0026, 0, 0, 0, 0, 0); ex("R5 emu ignores gating", K_IRQ, pair(1, 1));
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        ex("R9 pend cleared", K_PEND, 32'h24); ex("R9 active", K_ACT, pair(1, 1));
        ex("R10 hold", K_IRQ, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        ex("R11 empty", K_ACT, 0); ex("R11 none", K_IRQ, 0);
        cyc(1, 0, 16'h0030, 0, 0, 0, 0, 0); ex("R7 pwd first", K_IRQ, pair(1, 2));
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        ex("R9 active 2", K_ACT, pair(1, 2)); ex("R9 pend", K_PEND, 32'h20);
        ex("R10 lower no preempt", K_IRQ, 0);
        cyc(1, 2, 16'h0021, 0, 0, 0, 0, 0); ex("R10 preempt", K_IRQ, pair(1, 0));
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        ex("R9 nested", K_ACT, pair(1, 0)); ex("R9 pend nested", K_PEND, 32'h20);
        ex("R10 after nest", K_IRQ, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        ex("R11 restore", K_ACT, pair(1, 2)); ex("R11 hold", K_IRQ, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        ex("R11 empty again", K_ACT, 0); ex("R11 next", K_IRQ, pair(1, 5));
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        ex("R9 active 5", K_ACT, pair(1, 5)); ex("R9 pend empty", K_PEND, 0);
        cyc(1, 0, 16'h0020, 0, 0, 0, 0, 0); ex("R2 nest off", K_CTRL, 32'h20);
        cyc(1, 2, 16'h0001, 0, 0, 0, 0, 0); ex("R10 sequential hold", K_IRQ, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        ex("R11 pop", K_ACT, 0); ex("R10 R11 now offered", K_IRQ, pair(1, 0));
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        @(posedge clk); #8;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule